// File: doc/BRIEF.md
# Shared-Memory Multi-Queue Word FIFO Engine

This block keeps a set of independent 32-bit word FIFOs inside one shared, paged single-port memory. Each queue is placed and shaped by a packed configuration word. The word gives the first 16-word page of the queue, its length, and a low and a high fill threshold. The queue count and the memory size in pages are parameters. Software chooses the pages, so overlapping queues are a software error.

All traffic uses one register-style request port, which carries one access per cycle. A write to a queue's access address appends the word at the tail. A read from the same address removes the oldest word and returns it. Further addresses hold the configuration words, the packed per-queue status, and the sticky error flags. Every read answers exactly one cycle after its request. The per-queue empty, low, high and full flags are also driven as parallel output vectors.

Address map (8-bit word address): bits [7:6] select the region and bits [5:0] give the index. Region 0 is the queue access ports. Region 1 is the configuration words. Region 2 is the packed status words. Region 3 is the packed sticky flag words.

Top module: `mqf_engine`

## Requirements
- R1: The configuration word of queue q is at address 0x40+q and reads back as written. Its fields are: length code in bits [25:24] (0..3 gives 16, 32, 64, 128 words), base page in bits [21:14], low threshold in bits [28:26], high threshold in bits [31:29]. Writing it empties that queue.
- R2: A write to address q pushes the word into queue q. A read from address q returns the oldest word, in first-in first-out order. Every read answer has rsp_valid high, one cycle after the request.
- R3: A read from an allocated, empty queue returns 0 and sets that queue's sticky underflow flag.
- R4: A write to a full queue is dropped, leaving the stored words intact, and sets the sticky overflow flag.
- R5: Status word k at address 0x80+k packs queues 8k..8k+7, 4 bits each, with queue 8k+i at bits [4i+3:4i]. Within each group, bit 0 is empty, bit 1 low, bit 2 high and bit 3 full.
- R6: The low flag is set when the fill count is at or below the low threshold. The high flag is set when the free space (length minus count) is at or below the high threshold.
- R7: Sticky word j at address 0xC0+j packs queues 16j..16j+15, 2 bits each at bits [2i+1:2i], with bit 0 overflow and bit 1 underflow. Writing that word clears each flag whose data bit is 1.
- R8: After reset every configuration word is 0, every status group reads 0x3 and every sticky flag is 0.
- R9: A queue whose configuration word is 0 is unallocated. A push to it is dropped with no flag, and a pop from it returns 0 with no flag.
- R10: A queue's word i sits at memory word base*16 + pointer. Pointers wrap modulo the queue length, and queues on separate pages do not disturb each other.
- R11: The outputs q_empty, q_nearly_empty, q_nearly_full and q_full carry the same per-queue flags as the status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Word address: region in [7:6], index in [5:0] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read answer valid, one cycle after a read request |
| rsp_data | output | 32 | Read answer data |
| q_empty | output | NQ | Per-queue empty flag |
| q_nearly_empty | output | NQ | Per-queue low-threshold flag |
| q_nearly_full | output | NQ | Per-queue high-threshold flag |
| q_full | output | NQ | Per-queue full flag |

## Verification
Read answers, whether popped words or register contents, are due one cycle after the request edge. The bench holds a read for one cycle and samples rsp_data on the falling edge that follows. Fill counts, status flags and sticky flags change at the request edge itself, so the bench samples the flag vectors, or issues the next status read, only after that edge. Reset release takes two extra cycles through the synchronizer, and the bench waits those cycles before its first access.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

  localparam int WORD_W     = 32;
  localparam int PAGE_WORDS = 16;
  localparam int CNT_W      = 8;   // fill count 0..128
  localparam int PTR_W      = 7;   // pointer 0..127

  // Packed per-queue configuration word
  typedef struct packed {
    logic [2:0]  hi_wm;     // [31:29]
    logic [2:0]  lo_wm;     // [28:26]
    logic [1:0]  len_code;  // [25:24]
    logic [1:0]  spare_hi;  // [23:22]
    logic [7:0]  base_pg;   // [21:14]
    logic [13:0] spare_lo;  // [13:0]
  } qcfg_t;

  typedef enum logic [1:0] {
    RG_ACC  = 2'd0,
    RG_CFG  = 2'd1,
    RG_STAT = 2'd2,
    RG_STK  = 2'd3
  } region_e;

  function automatic logic [CNT_W-1:0] qlen(input logic [1:0] code);
    return CNT_W'(PAGE_WORDS) << code;
  endfunction

endpackage

// File: rtl/mqf_sram.sv
module mqf_sram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mqf_queue_ctl.sv
module mqf_queue_ctl
  import mqf_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [1:0]        stk_clr,
  output logic [WORD_W-1:0] cfg_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              st_empty_o,
  output logic              st_low_o,
  output logic              st_high_o,
  output logic              st_full_o,
  output logic [1:0]        sticky_o
);

  qcfg_t            cfg_q, cfg_d;
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, udf_q, udf_d;
  logic             cfg_en, ptr_en, stk_en;

  logic [CNT_W-1:0] len, free_sp, wrap_mask;
  logic             allocated, is_empty, is_full;
  logic             push_ok, pop_ok, set_ovf, set_udf;
  logic [12:0]      phys_addr;

  assign len       = qlen(cfg_q.len_code);
  assign wrap_mask = len - CNT_W'(1);
  assign allocated = |cfg_q;
  assign is_empty  = (cnt_q == '0);
  assign is_full   = (cnt_q == len);
  assign free_sp   = len - cnt_q;

  assign push_ok = push_req & allocated & ~is_full;
  assign pop_ok  = pop_req  & allocated & ~is_empty;
  assign set_ovf = push_req & allocated &  is_full;
  assign set_udf = pop_req  & allocated &  is_empty;

  // Memory word = base page * 16 + active pointer
  always_comb begin
    phys_addr = {1'b0, cfg_q.base_pg, 4'b0000}
              + {6'b0, (push_req ? tail_q : head_q)};
  end
  assign mem_addr_o = phys_addr[AW-1:0];

  // Next-state logic
  always_comb begin
    cfg_d  = cfg_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    udf_d  = udf_q;
    if (cfg_we) begin
      cfg_d  = qcfg_t'(cfg_wdata);
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) begin
        tail_d = (tail_q + PTR_W'(1)) & wrap_mask[PTR_W-1:0];
        cnt_d  = cnt_q + CNT_W'(1);
      end
      if (pop_ok) begin
        head_d = (head_q + PTR_W'(1)) & wrap_mask[PTR_W-1:0];
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
    if (set_ovf)    ovf_d = 1'b1;
    if (stk_clr[0]) ovf_d = 1'b0;
    if (set_udf)    udf_d = 1'b1;
    if (stk_clr[1]) udf_d = 1'b0;
  end

  assign cfg_en = cfg_we;
  assign ptr_en = cfg_we | push_ok | pop_ok;
  assign stk_en = set_ovf | set_udf | (|stk_clr);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (stk_en) begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign push_ok_o  = push_ok;
  assign pop_ok_o   = pop_ok;
  assign st_empty_o = is_empty;
  assign st_full_o  = is_full;
  assign st_low_o   = (cnt_q <= CNT_W'(cfg_q.lo_wm));
  assign st_high_o  = (free_sp <= CNT_W'(cfg_q.hi_wm));
  assign sticky_o   = {udf_q, ovf_q};

endmodule

// File: rtl/mqf_engine.sv
module mqf_engine
  import mqf_pkg::*;
#(
  parameter int NQ    = 16,
  parameter int PAGES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [7:0]    req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic [NQ-1:0] q_empty,
  output logic [NQ-1:0] q_nearly_empty,
  output logic [NQ-1:0] q_nearly_full,
  output logic [NQ-1:0] q_full
);

  localparam int MEM_DEPTH = PAGES * PAGE_WORDS;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int NSTAT     = (NQ + 7) / 8;
  localparam int NSTK      = (NQ + 15) / 16;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Decode
  region_e    region;
  logic [5:0] idx;
  assign region = region_e'(req_addr[7:6]);
  assign idx    = req_addr[5:0];

  logic [NQ-1:0]     cfg_we, push_req, pop_req, push_ok, pop_ok;
  logic [1:0]        stk_clr [NQ];
  logic [1:0]        sticky  [NQ];
  logic [31:0]       cfg_arr [NQ];
  logic [MEM_AW-1:0] qaddr   [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign cfg_we[q]   = req_valid &  req_write & (region == RG_CFG) & (idx == 6'(q));
    assign push_req[q] = req_valid &  req_write & (region == RG_ACC) & (idx == 6'(q));
    assign pop_req[q]  = req_valid & ~req_write & (region == RG_ACC) & (idx == 6'(q));
    assign stk_clr[q]  = (req_valid & req_write & (region == RG_STK) & (idx == 6'(q / 16)))
                         ? req_wdata[2*(q%16) +: 2] : 2'b00;

    mqf_queue_ctl #(.AW(MEM_AW)) u_qctl (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .cfg_we     (cfg_we[q]),
      .cfg_wdata  (req_wdata),
      .push_req   (push_req[q]),
      .pop_req    (pop_req[q]),
      .stk_clr    (stk_clr[q]),
      .cfg_o      (cfg_arr[q]),
      .mem_addr_o (qaddr[q]),
      .push_ok_o  (push_ok[q]),
      .pop_ok_o   (pop_ok[q]),
      .st_empty_o (q_empty[q]),
      .st_low_o   (q_nearly_empty[q]),
      .st_high_o  (q_nearly_full[q]),
      .st_full_o  (q_full[q]),
      .sticky_o   (sticky[q])
    );
  end

  // Shared memory port arbitration (at most one queue active per cycle)
  logic              mem_we, mem_re;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_rdata;

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = '0;
    for (int q = 0; q < NQ; q++) begin
      if (push_ok[q] | pop_ok[q]) mem_addr = qaddr[q];
      if (push_ok[q])             mem_we   = 1'b1;
    end
  end
  assign mem_re = |pop_ok;

  mqf_sram #(.DEPTH(MEM_DEPTH), .AW(MEM_AW), .DW(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  // Packed status images
  logic [NSTAT*32-1:0] stat_flat;
  logic [NSTK*32-1:0]  stk_flat;

  always_comb begin
    stat_flat = '0;
    stk_flat  = '0;
    for (int q = 0; q < NQ; q++) begin
      stat_flat[4*q +: 4] = {q_full[q], q_nearly_full[q], q_nearly_empty[q], q_empty[q]};
      stk_flat[2*q +: 2]  = sticky[q];
    end
  end

  // Register read mux
  logic [31:0] rd_d, rd_q;
  logic        rsp_d, rsp_q, sel_mem_d, sel_mem_q, rsp_en;

  always_comb begin
    rd_d = '0;
    unique case (region)
      RG_CFG: begin
        for (int q = 0; q < NQ; q++)
          if (idx == 6'(q)) rd_d = cfg_arr[q];
      end
      RG_STAT: begin
        for (int w = 0; w < NSTAT; w++)
          if (idx == 6'(w)) rd_d = stat_flat[32*w +: 32];
      end
      RG_STK: begin
        for (int w = 0; w < NSTK; w++)
          if (idx == 6'(w)) rd_d = stk_flat[32*w +: 32];
      end
      default: rd_d = '0;
    endcase
  end

  assign rsp_d     = req_valid & ~req_write;
  assign sel_mem_d = mem_re;
  assign rsp_en    = rsp_d | rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q     <= 1'b0;
      sel_mem_q <= 1'b0;
      rd_q      <= '0;
    end else if (rsp_en) begin
      rsp_q     <= rsp_d;
      sel_mem_q <= sel_mem_d;
      rd_q      <= rd_d;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = sel_mem_q ? mem_rdata : rd_q;

endmodule

// File: rtl/mqf_chk.sv
module mqf_chk #(
  parameter int NQ = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [7:0]    req_addr,
  input logic          rsp_valid,
  input logic [31:0]   rsp_data,
  input logic [NQ-1:0] q_empty,
  input logic [NQ-1:0] q_nearly_empty,
  input logic [NQ-1:0] q_nearly_full,
  input logic [NQ-1:0] q_full
);

  logic acc_rd, acc_wr, pop_empty, push_full;

  assign acc_rd = req_valid & ~req_write & (req_addr[7:6] == 2'd0);
  assign acc_wr = req_valid &  req_write & (req_addr[7:6] == 2'd0);

  always_comb begin
    pop_empty = 1'b0;
    push_full = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (req_addr[5:0] == 6'(i)) begin
        pop_empty = acc_rd & q_empty[i];
        push_full = acc_wr & q_full[i];
      end
    end
  end

  // R2: every read is answered one cycle later, nothing else is
  a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R3, R9: a pop of an empty or unallocated queue answers zero
  a_r3_pop_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> (rsp_data == 32'd0));

  // R4: a push to a full queue leaves it full
  a_r4_full_push_stable: assert property (@(posedge clk) disable iff (!rst_n)
    push_full |=> $stable(q_full));

  // R6: empty implies low, full implies high
  a_r6_empty_implies_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_empty & ~q_nearly_empty) == '0));
  a_r6_full_implies_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_full & ~q_nearly_full) == '0));

  // R11: empty and full never together
  a_r11_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_empty & q_full) == '0));

endmodule

bind mqf_engine mqf_chk #(.NQ(NQ)) u_mqf_chk (
  .clk            (clk),
  .rst_n          (rst_core_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .req_addr       (req_addr),
  .rsp_valid      (rsp_valid),
  .rsp_data       (rsp_data),
  .q_empty        (q_empty),
  .q_nearly_empty (q_nearly_empty),
  .q_nearly_full  (q_nearly_full),
  .q_full         (q_full)
);

// File: tb/tb_mqf_engine.sv
module tb_mqf_engine;

  localparam int NQ = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [7:0]    req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic [NQ-1:0] q_empty, q_nearly_empty, q_nearly_full, q_full;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  mqf_engine #(.NQ(NQ), .PAGES(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .q_empty(q_empty), .q_nearly_empty(q_nearly_empty),
    .q_nearly_full(q_nearly_full), .q_full(q_full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      checks++; failures++;
      $display("FAIL R2: rsp_valid actual=%0b expected=1", rsp_valid);
    end
    d = rsp_data;
  endtask

  function automatic logic [31:0] mkcfg(input logic [1:0] code, input logic [7:0] pg,
                                        input logic [2:0] lo, input logic [2:0] hi);
    return {hi, lo, code, 2'b00, pg, 14'd0};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h80, d); chk("R8 status word0", d, 32'h3333_3333);
    rd(8'h81, d); chk("R8 status word1", d, 32'h3333_3333);
    rd(8'hC0, d); chk("R8 sticky word0", d, 32'h0);
    rd(8'h47, d); chk("R8 cfg q7", d, 32'h0);
    chk("R11 q_empty after reset", 32'(q_empty), 32'h0000_FFFF);
    chk("R11 q_nearly_empty after reset", 32'(q_nearly_empty), 32'h0000_FFFF);
  endtask

  task automatic t_config_order();
    logic [31:0] d;
    wr(8'h40, mkcfg(2'd0, 8'd1, 3'd0, 3'd0));
    wr(8'h41, mkcfg(2'd1, 8'd2, 3'd1, 3'd1));
    rd(8'h41, d); chk("R1 cfg readback q1", d, mkcfg(2'd1, 8'd2, 3'd1, 3'd1));
    for (int i = 0; i < 3; i++) wr(8'h00, 32'hA000_0001 + 32'(i));
    for (int i = 0; i < 3; i++) begin
      rd(8'h00, d); chk("R2 fifo order q0", d, 32'hA000_0001 + 32'(i));
    end
    chk("R11 q0 empty after drain", 32'(q_empty[0]), 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) wr(8'h01, 32'hB000_0000 + 32'(i));
    for (int i = 0; i < 16; i++) wr(8'h00, 32'hC000_0000 + 32'(i));
    chk("R4 q_full[0]", 32'(q_full[0]), 32'h1);
    rd(8'h80, d); chk("R5 status q0 full group", 32'(d[3:0]), 32'hC);
    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'hC0, d); chk("R4 overflow sticky", d, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(8'h00, d); chk("R4 contents intact", d, 32'hC000_0000 + 32'(i));
    end
    rd(8'h00, d); chk("R3 empty pop zero", d, 32'h0);
    rd(8'hC0, d); chk("R3 underflow sticky", d, 32'h3);
    wr(8'hC0, 32'h1);
    rd(8'hC0, d); chk("R7 clear overflow only", d, 32'h2);
    wr(8'hC0, 32'h2);
    rd(8'hC0, d); chk("R7 clear underflow", d, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 10; i++) wr(8'h00, 32'hE000_0000 + 32'(r*16 + i));
      for (int i = 0; i < 10; i++) begin
        rd(8'h00, d); chk("R10 wrap order q0", d, 32'hE000_0000 + 32'(r*16 + i));
      end
    end
    for (int i = 0; i < 5; i++) begin
      rd(8'h01, d); chk("R10 neighbour q1 intact", d, 32'hB000_0000 + 32'(i));
    end
  endtask

  task automatic t_watermark();
    logic [31:0] d;
    wr(8'h42, mkcfg(2'd0, 8'd4, 3'd2, 3'd3));
    rd(8'h80, d); chk("R6 q2 empty group", 32'(d[11:8]), 32'h3);
    wr(8'h02, 32'h1);
    rd(8'h80, d); chk("R6 q2 count1 low", 32'(d[11:8]), 32'h2);
    wr(8'h02, 32'h2);
    rd(8'h80, d); chk("R6 q2 count2 low", 32'(d[11:8]), 32'h2);
    wr(8'h02, 32'h3);
    rd(8'h80, d); chk("R6 q2 count3 clear", 32'(d[11:8]), 32'h0);
    for (int i = 3; i < 12; i++) wr(8'h02, 32'(i + 1));
    chk("R6 q2 count12 not high", 32'(q_nearly_full[2]), 32'h0);
    wr(8'h02, 32'hD);
    chk("R6 q2 count13 high", 32'(q_nearly_full[2]), 32'h1);
    rd(8'h80, d); chk("R5 q2 count13 group", 32'(d[11:8]), 32'h4);
  endtask

  task automatic t_unalloc();
    logic [31:0] d;
    wr(8'h05, 32'h1234_5678);
    rd(8'h05, d); chk("R9 unallocated pop zero", d, 32'h0);
    rd(8'hC0, d); chk("R9 no sticky flag", d, 32'h0);
    rd(8'h80, d); chk("R9 q5 group unchanged", 32'(d[23:20]), 32'h3);
  endtask

  task automatic t_reconfig_word1();
    logic [31:0] d;
    wr(8'h43, mkcfg(2'd0, 8'd5, 3'd0, 3'd0));
    wr(8'h03, 32'h11); wr(8'h03, 32'h22);
    rd(8'h80, d); chk("R5 q3 two words", 32'(d[15:12]), 32'h0);
    wr(8'h43, mkcfg(2'd0, 8'd5, 3'd0, 3'd0));
    rd(8'h80, d); chk("R1 rewrite empties q3", 32'(d[15:12]), 32'h3);
    wr(8'h49, mkcfg(2'd0, 8'd6, 3'd0, 3'd0));
    wr(8'h09, 32'h99);
    rd(8'h81, d); chk("R5 word1 packing q9", d, 32'h3333_3303);
    rd(8'h09, d); chk("R2 q9 pop", d, 32'h99);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_config_order();
    t_overflow();
    t_wrap();
    t_watermark();
    t_unalloc();
    t_reconfig_word1();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule